// File: doc/BRIEF.md
# Write Permission Gate for an Asymmetric Block Array

This block decides, one request at a time, whether a program or erase aimed at a byte address may change a 256 KiB non-volatile array. The array is cut into seven blocks of unequal size. The block decodes the address into a block index. It then weighs four things: the per-block lock bits, two active-low hardware protect pins that each cover their own group of blocks, the bus interface that is selected, and a digital flag that says whether the programming supply is above its lockout level.

Each request gives a registered response one clock later. The response holds the block index, a permit bit, and one of two error pulses: one for supply lockout and one for block protection. A status register can capture these pulses. The lock bits are written through a small port with a write strobe, a block index and a value. Reset clears every lock bit.

Top module: `wprot_gate`

## Requirements
- R1: The block index follows this map of the 18-bit address: 0x00000–0x0FFFF gives 0, 0x10000–0x1FFFF gives 1, 0x20000–0x2FFFF gives 2, 0x30000–0x37FFF gives 3, 0x38000–0x39FFF gives 4, 0x3A000–0x3BFFF gives 5, and 0x3C000–0x3FFFF gives 6, which is the boot block.
- R2: A request sampled with `req_valid` high on a rising edge drives `resp_valid`, `resp_blk`, `resp_permit` and one error flag in the cycle right after that edge. With no request, all of these outputs are 0 in the next cycle.
- R3: When `top_lock_n` is low, a request to block 6 is refused with `err_prot`, whatever its lock bit holds. When `top_lock_n` is high, a request to block 6 is refused exactly when lock bit 6 is 1.
- R4: When `wr_prot_n` is low, a request to any of blocks 0 to 5 is refused with `err_prot`, whatever the lock bits hold. When `wr_prot_n` is high, such a request is refused exactly when the lock bit of its block is 1.
- R5: `top_lock_n` has no effect on blocks 0 to 5, and `wr_prot_n` has no effect on block 6.
- R6: While `prog_if_sel` is 1, which selects the programmer interface, every block is permitted, regardless of the pins and the lock bits. Lock writes made in this mode are dropped.
- R7: When `vpp_ok` is 0, every request is refused. `err_supply` is 1 and `err_prot` is 0, in any mode and for any block.
- R8: A synchronous reset clears all lock bits to 0, which means unlocked, and clears all response outputs.
- R9: A lock write with `lock_we` high sets lock bit `lock_idx` to `lock_val` on the clock edge. A lock write with an index of 7 or above changes nothing. A request in the same cycle as a lock write sees the old lock value.
- R10: `err_supply` and `err_prot` are never 1 together. A permitted request raises neither of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Program or erase request strobe |
| req_addr | input | 18 | Byte address of the request |
| top_lock_n | input | 1 | Active-low boot-block protect pin |
| wr_prot_n | input | 1 | Active-low protect pin for blocks 0 to 5 |
| prog_if_sel | input | 1 | 1 selects the programmer interface (no protection) |
| vpp_ok | input | 1 | Programming supply is above its lockout level |
| lock_we | input | 1 | Lock bit write strobe |
| lock_idx | input | 3 | Block index of the lock write |
| lock_val | input | 1 | Value written to the lock bit |
| resp_valid | output | 1 | Response present this cycle |
| resp_blk | output | 3 | Decoded block index |
| resp_permit | output | 1 | Request may modify the array |
| err_supply | output | 1 | One-cycle pulse: refused for supply lockout |
| err_prot | output | 1 | One-cycle pulse: refused for block protection |

## Verification
The hardest case to reach is one where a lock bit must stay untouched by a write made in programmer mode, or by a write with an index out of range. Neither write shows at the outputs while programmer mode is on. The stimulus therefore issues such writes, leaves programmer mode, and probes every block with both protect pins high. Each lock bit then shows up directly as permit or refusal. The main sweep loads several lock patterns. For each pattern it crosses every block's lower bound, upper bound and midpoint with all sixteen combinations of the pins, the mode and the supply flag. A second sweep walks the whole address space in coarse steps, plus each boundary ±1, to check the map.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int ADDR_W  = 18;
  localparam int NUM_BLK = 7;
  localparam int BLK_W   = $clog2(NUM_BLK);
  localparam int TOP_BLK = NUM_BLK - 1;

  // Lower bound of each block; entry NUM_BLK is one past the array end.
  localparam logic [ADDR_W:0] BLK_BASE [0:NUM_BLK] = '{
    19'h00000, 19'h10000, 19'h20000, 19'h30000,
    19'h38000, 19'h3A000, 19'h3C000, 19'h40000
  };

  typedef struct packed {
    logic permit;
    logic e_sup;
    logic e_prot;
  } verdict_t;
endpackage

// File: rtl/wprot_blkmap.sv
module wprot_blkmap
  import wprot_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_BLK-1:0] hit,
  output logic [BLK_W-1:0]   blk
);
  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr};

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_cmp
    assign hit[i] = (addr_x >= BLK_BASE[i]) && (addr_x < BLK_BASE[i+1]);
  end

  always_comb begin
    blk = '0;
    for (int i = 0; i < NUM_BLK; i++)
      if (hit[i]) blk = BLK_W'(i);
  end
endmodule

// File: rtl/wprot_lockreg.sv
module wprot_lockreg
  import wprot_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               prog_if,
  input  logic [BLK_W-1:0]   idx,
  input  logic               val,
  output logic [NUM_BLK-1:0] lock_q
);
  logic idx_ok;
  assign idx_ok = idx < BLK_W'(NUM_BLK);

  always_ff @(posedge clk) begin
    if (rst)
      lock_q <= '0;
    else if (we && !prog_if && idx_ok)
      lock_q[idx] <= val;
  end

  // R6 / R9: dropped writes leave every lock bit unchanged
  assert_drop_write_R9: assert property (@(posedge clk) disable iff (rst)
    (we && (prog_if || !idx_ok)) |=> $stable(lock_q));
endmodule

// File: rtl/wprot_decide.sv
module wprot_decide
  import wprot_pkg::*;
(
  input  logic [BLK_W-1:0]   blk,
  input  logic [NUM_BLK-1:0] lock_q,
  input  logic               top_lock_n,
  input  logic               wr_prot_n,
  input  logic               prog_if,
  input  logic               vpp_ok,
  output verdict_t           v
);
  logic is_top, pin_block, locked;

  assign is_top    = (blk == BLK_W'(TOP_BLK));
  assign pin_block = is_top ? !top_lock_n : !wr_prot_n;
  assign locked    = lock_q[blk];

  always_comb begin
    v = '0;
    if (!vpp_ok)
      v.e_sup = 1'b1;
    else if (prog_if)
      v.permit = 1'b1;
    else if (pin_block || locked)
      v.e_prot = 1'b1;
    else
      v.permit = 1'b1;
  end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
  import wprot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              top_lock_n,
  input  logic              wr_prot_n,
  input  logic              prog_if_sel,
  input  logic              vpp_ok,
  input  logic              lock_we,
  input  logic [BLK_W-1:0]  lock_idx,
  input  logic              lock_val,
  output logic              resp_valid,
  output logic [BLK_W-1:0]  resp_blk,
  output logic              resp_permit,
  output logic              err_supply,
  output logic              err_prot
);
  logic [NUM_BLK-1:0] hit;
  logic [BLK_W-1:0]   blk;
  logic [NUM_BLK-1:0] lock_q;
  verdict_t           v;

  wprot_blkmap u_map (.addr(req_addr), .hit(hit), .blk(blk));

  wprot_lockreg u_lock (
    .clk(clk), .rst(rst), .we(lock_we), .prog_if(prog_if_sel),
    .idx(lock_idx), .val(lock_val), .lock_q(lock_q)
  );

  wprot_decide u_dec (
    .blk(blk), .lock_q(lock_q), .top_lock_n(top_lock_n),
    .wr_prot_n(wr_prot_n), .prog_if(prog_if_sel), .vpp_ok(vpp_ok), .v(v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_blk    <= '0;
      resp_permit <= 1'b0;
      err_supply  <= 1'b0;
      err_prot    <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_blk    <= req_valid ? blk : '0;
      resp_permit <= req_valid && v.permit;
      err_supply  <= req_valid && v.e_sup;
      err_prot    <= req_valid && v.e_prot;
    end
  end

  // R1: every address lands in exactly one block
  assert_one_block_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $countones(hit) == 1);
  // R10: error flags are exclusive and never accompany a permit
  assert_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(err_supply && err_prot) && !(resp_permit && (err_supply || err_prot)));
  // R7: a low supply always refuses with the supply error
  assert_supply_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !vpp_ok) |=> (err_supply && !resp_permit));
  // R6: programmer interface permits whenever supply is fine
  assert_prog_if_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && vpp_ok && prog_if_sel) |=> resp_permit);
  // R3: boot block pin overrides the lock bits
  assert_top_pin_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && vpp_ok && !prog_if_sel && !top_lock_n && req_addr >= 18'h3C000)
      |=> (err_prot && !resp_permit));
  // R4: write-protect pin overrides the lock bits for blocks 0 to 5
  assert_wp_pin_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && vpp_ok && !prog_if_sel && !wr_prot_n && req_addr < 18'h3C000)
      |=> (err_prot && !resp_permit));
  // R2: no request, no response
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(resp_valid || resp_permit || err_supply || err_prot));
endmodule

// File: tb/wprot_gate_bench.sv
module wprot_gate_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [17:0] req_addr;
  logic        top_lock_n, wr_prot_n, prog_if_sel, vpp_ok;
  logic        lock_we;
  logic [2:0]  lock_idx;
  logic        lock_val;
  logic        resp_valid;
  logic [2:0]  resp_blk;
  logic        resp_permit, err_supply, err_prot;

  int checks = 0;
  int fails  = 0;
  logic [6:0] mlock;
  bit done = 0;

  always #2.5 clk = ~clk;

  wprot_gate u_wprot_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .top_lock_n(top_lock_n), .wr_prot_n(wr_prot_n), .prog_if_sel(prog_if_sel),
    .vpp_ok(vpp_ok), .lock_we(lock_we), .lock_idx(lock_idx), .lock_val(lock_val),
    .resp_valid(resp_valid), .resp_blk(resp_blk), .resp_permit(resp_permit),
    .err_supply(err_supply), .err_prot(err_prot)
  );

  function automatic logic [2:0] exp_blk(input int a);
    if (a < 'h10000) return 0;
    if (a < 'h20000) return 1;
    if (a < 'h30000) return 2;
    if (a < 'h38000) return 3;
    if (a < 'h3A000) return 4;
    if (a < 'h3C000) return 5;
    return 6;
  endfunction

  // expected {permit, e_sup, e_prot}
  function automatic logic [2:0] exp_verdict(input int a, input logic tl, wp, pi, vo);
    logic [2:0] b;
    b = exp_blk(a);
    if (!vo) return 3'b010;
    if (pi) return 3'b100;
    if (b == 6) return (!tl || mlock[6]) ? 3'b001 : 3'b100;
    return (!wp || mlock[b]) ? 3'b001 : 3'b100;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input int a, input logic tl, wp, pi, vo, input string req);
    logic [2:0] e;
    @(negedge clk);
    req_valid = 1; req_addr = a[17:0];
    top_lock_n = tl; wr_prot_n = wp; prog_if_sel = pi; vpp_ok = vo;
    @(negedge clk);
    req_valid = 0;
    e = exp_verdict(a, tl, wp, pi, vo);
    check({req, " verdict"}, {resp_permit, err_supply, err_prot}, e);
    check({req, " blk R1"}, {resp_valid, resp_blk}, {1'b1, exp_blk(a)});
  endtask

  task automatic wr_lock(input int idx, input logic val, input logic pi);
    @(negedge clk);
    lock_we = 1; lock_idx = idx[2:0]; lock_val = val; prog_if_sel = pi;
    @(negedge clk);
    lock_we = 0; prog_if_sel = 0;
    if (!pi && idx < 7) mlock[idx] = val;
  endtask

  task automatic probe_all(input string req);
    int pts[7] = '{'h08000, 'h18000, 'h28000, 'h34000, 'h39000, 'h3B000, 'h3E000};
    foreach (pts[k]) do_req(pts[k], 1, 1, 0, 1, req);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bnd[8] = '{0, 'h10000, 'h20000, 'h30000, 'h38000, 'h3A000, 'h3C000, 'h40000};
    int pats[4] = '{'h00, 'h7F, 'h55, 'h2A};
    rst = 1; req_valid = 0; req_addr = 0; top_lock_n = 1; wr_prot_n = 1;
    prog_if_sel = 0; vpp_ok = 1; lock_we = 0; lock_idx = 0; lock_val = 0;
    mlock = '0;
    repeat (3) @(negedge clk);
    // R8: reset state of outputs
    check("R8 reset outputs", {resp_valid, resp_blk, resp_permit, err_supply, err_prot}, 0);
    rst = 0;

    // R3 R4 R5 R6 R7 R10: exhaustive control cross per lock pattern
    foreach (pats[p]) begin
      for (int b = 0; b < 7; b++) wr_lock(b, pats[p][b], 0);
      for (int b = 0; b < 7; b++) begin
        int as[3];
        as[0] = bnd[b]; as[1] = bnd[b+1] - 1; as[2] = (bnd[b] + bnd[b+1]) / 2;
        foreach (as[k])
          for (int c = 0; c < 16; c++)
            do_req(as[k], c[0], c[1], c[2], c[3], "R3/R4/R5/R6/R7/R10");
      end
    end

    // R2: response is a single-cycle pulse
    do_req('h3E000, 0, 1, 0, 1, "R3 top pin");
    @(negedge clk);
    check("R2 idle after pulse", {resp_valid, resp_permit, err_supply, err_prot}, 0);

    // R1: address map sweep, coarse plus each boundary +/-1
    for (int a = 0; a < 'h40000; a += 'h400) do_req(a, 1, 1, 1, 1, "R1 sweep");
    for (int b = 1; b < 7; b++) begin
      do_req(bnd[b] - 1, 1, 1, 1, 1, "R1 edge low");
      do_req(bnd[b], 1, 1, 1, 1, "R1 edge high");
    end

    // R9: out-of-range index ignored; R6: writes in programmer mode dropped
    for (int b = 0; b < 7; b++) wr_lock(b, 0, 0);
    wr_lock(7, 1, 0);
    probe_all("R9 idx7 ignored");
    for (int b = 0; b < 7; b++) wr_lock(b, 1, 1);
    probe_all("R6 writes dropped in programmer mode");

    // R9: request in the same cycle as a write sees the old value
    @(negedge clk);
    lock_we = 1; lock_idx = 3; lock_val = 1;
    req_valid = 1; req_addr = 'h34000; top_lock_n = 1; wr_prot_n = 1; vpp_ok = 1;
    @(negedge clk);
    lock_we = 0; req_valid = 0;
    check("R9 same-cycle old value", {resp_permit, err_prot}, 2'b10);
    mlock[3] = 1;
    do_req('h34000, 1, 1, 0, 1, "R9 new value visible");

    // R8: reset clears locks
    for (int b = 0; b < 7; b++) wr_lock(b, 1, 0);
    probe_all("R9 all locked");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    mlock = '0;
    probe_all("R8 locks cleared");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule